// File: doc/BRIEF.md
# Translation Lookaside Buffer with Entry Lockdown

This block is a fully associative cache of virtual-to-physical address mappings. Each entry covers one of three region sizes: a 4KB small page, a 64KB large page or a 1MB section. Entries of all three sizes sit side by side in the same array. The block answers a lookup in the same cycle. It returns hit or miss, the translated physical address, the 4-bit domain number, the two access-permission bits and the two cacheable/bufferable bits of the matching entry. While translation is switched off, it passes the virtual address through unchanged.

A table walker outside the block supplies refills. Each refill writes one entry, and a rotating pointer chooses that entry. The pointer steps through the unlocked part of the array and never lands on a locked entry. Locking is set by a base count: every entry whose index is below that count is locked and can no longer be chosen for replacement. Two maintenance commands exist. One clears every entry. The other clears only the entries that cover a given virtual address. Permission checking and the table walk itself are done elsewhere.

Top module: `xlate_tlb`

## Requirements
- R1: After reset no entry is valid and the refill pointer is 0. While `xlateEn` is 0, `lookupPa` equals `lookupVa`, `lookupHit` is 0, and the domain, permission and cache-attribute outputs are 0.
- R2: While `xlateEn` is 1, a valid entry that matches `lookupVa` drives `lookupHit` high in the same cycle. It also drives `lookupDomain`, `lookupAp` and `lookupCb` from that entry.
- R3: The size code sets how many address bits an entry compares. 2'b00 is a small page and compares VA[31:12]. 2'b01 is a large page and compares VA[31:16]. 2'b10 is a section and compares VA[31:20]. A refill with code 2'b11 is dropped: nothing is written and the pointer does not move.
- R4: On a hit, `lookupPa` takes the entry's physical base bits above the size boundary and the lookup address bits below it. VA[11:0] always passes straight through.
- R5: On a miss with `xlateEn` at 1, `lookupHit` is 0, `lookupPa` equals `lookupVa`, and the other lookup outputs are 0.
- R6: An accepted refill writes its entry at the next rising clock edge, at the victim index. The victim is the pointer, raised to `lockBase` if the pointer is below it. After the write the pointer moves to victim+1. If the victim was ENTRIES-1, the pointer wraps to `lockBase` instead.
- R7: Entries with an index below `lockBase` are never written by a refill. If `lockBase` is ENTRIES or larger, every refill is dropped.
- R8: `invAll` clears every entry at the next rising edge, locked entries included.
- R9: `invEntry` clears, at the next rising edge, every valid entry that matches `invVa` under its own size rule (R3). Other entries are left untouched, locked or not.
- R10: When commands arrive in the same cycle, `invAll` takes priority over `invEntry`, which takes priority over a refill. A command that loses is dropped and does not move the pointer.
- R11: When more than one valid entry matches a lookup, the entry with the lowest index supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| xlateEn | input | 1 | Translation enable; 0 passes addresses through |
| lookupVa | input | 32 | Virtual address to translate |
| lookupHit | output | 1 | A valid entry matches `lookupVa` |
| lookupPa | output | 32 | Translated address, or `lookupVa` on a miss or while disabled |
| lookupDomain | output | 4 | Domain number of the matching entry |
| lookupAp | output | 2 | Access-permission bits of the matching entry |
| lookupCb | output | 2 | Cacheable/bufferable bits of the matching entry |
| fillEn | input | 1 | Refill request |
| fillVa | input | 32 | Virtual address of the refill |
| fillPa | input | 32 | Physical base of the refill |
| fillSize | input | 2 | Size code of the refill (see R3) |
| fillDomain | input | 4 | Domain of the refill |
| fillAp | input | 2 | Access-permission bits of the refill |
| fillCb | input | 2 | Cacheable/bufferable bits of the refill |
| invAll | input | 1 | Clear every entry |
| invEntry | input | 1 | Clear the entries that match `invVa` |
| invVa | input | 32 | Address used by `invEntry` |
| lockBase | input | $clog2(ENTRIES)+1 | Entries below this index are locked |

## Verification
The checker tests, on every cycle, the following:
- the pass-through while translation is off;
- the untouched page offset on every hit;
- that no write ever targets a locked or out-of-range index;
- that back-to-back refills step the pointer and wrap it to the lock base;
- that the internal write and clear strobes never fire together;
- that a dropped reserved-size refill produces no write;
- that no lookup hits in the cycle after a full clear.

Other behaviour depends on what the entries hold, so only the bench's scenarios show it. That covers the translated address for each of the three sizes, the exact compare width at the size boundaries, and lowest-index priority between a section and a page that overlap. It also covers which entries survive a clear by address, and that locked entries are still present after the array has been cycled through many times.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int ADDR_W  = 32;
  localparam int PAGE_LO = 12;
  localparam int FRAME_W = ADDR_W - PAGE_LO;
  localparam int DOM_W   = 4;
  localparam int AP_W    = 2;
  localparam int CB_W    = 2;
  localparam int STB_IDX_W = 8;

  typedef enum logic [1:0] {
    SZ_SMALL   = 2'b00,
    SZ_LARGE   = 2'b01,
    SZ_SECTION = 2'b10,
    SZ_RSVD    = 2'b11
  } pageSize_e;

  typedef struct packed {
    logic               valid;
    pageSize_e          size;
    logic [FRAME_W-1:0] tag;
    logic [FRAME_W-1:0] base;
    logic [DOM_W-1:0]   domain;
    logic [AP_W-1:0]    ap;
    logic [CB_W-1:0]    cb;
  } tlbEntry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                 invAll;
    logic                 invOne;
    logic                 writeEn;
    logic [STB_IDX_W-1:0] writeIdx;
  } tlbStrobe_t;

  // ones over the frame bits an entry of this size compares
  function automatic logic [FRAME_W-1:0] sizeMask(pageSize_e s);
    case (s)
      SZ_SMALL:   sizeMask = '1;
      SZ_LARGE:   sizeMask = {{(FRAME_W-4){1'b1}}, 4'h0};
      default:    sizeMask = {{(FRAME_W-8){1'b1}}, 8'h00};
    endcase
  endfunction

  function automatic logic entryMatch(tlbEntry_t e, logic [ADDR_W-1:0] va);
    entryMatch = e.valid &&
                 (((va[ADDR_W-1:PAGE_LO] ^ e.tag) & sizeMask(e.size)) == '0);
  endfunction
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         fillEn,
  input  logic [1:0]   fillSize,
  input  logic         invAll,
  input  logic         invEntry,
  input  logic [IDX_W:0] lockBase,
  output tlbStrobe_t   strobe
);
  localparam logic [IDX_W:0] LAST_IDX  = (IDX_W+1)'(ENTRIES - 1);
  localparam logic [IDX_W:0] ENT_COUNT = (IDX_W+1)'(ENTRIES);

  logic [IDX_W:0] ptr;
  logic [IDX_W:0] victim;
  logic [IDX_W:0] ptrNext;
  logic           roomLeft;
  logic           sizeOk;
  logic           doFill;

  always_comb begin
    roomLeft = lockBase < ENT_COUNT;
    victim   = (ptr < lockBase) ? lockBase : ptr;
    sizeOk   = fillSize != SZ_RSVD;
    doFill   = fillEn && sizeOk && roomLeft && !invAll && !invEntry;
    ptrNext  = ptr;
    if (doFill) begin
      ptrNext = (victim >= LAST_IDX) ? lockBase : victim + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptr <= '0;
    else       ptr <= ptrNext;
  end

  always_comb begin
    strobe.invAll   = invAll;
    strobe.invOne   = invEntry && !invAll;
    strobe.writeEn  = doFill;
    strobe.writeIdx = STB_IDX_W'(victim);
  end
endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobe_t        strobe,
  input  logic              xlateEn,
  input  logic [ADDR_W-1:0] lookupVa,
  input  logic [ADDR_W-1:0] fillVa,
  input  logic [ADDR_W-1:0] fillPa,
  input  logic [1:0]        fillSize,
  input  logic [DOM_W-1:0]  fillDomain,
  input  logic [AP_W-1:0]   fillAp,
  input  logic [CB_W-1:0]   fillCb,
  input  logic [ADDR_W-1:0] invVa,
  output logic              lookupHit,
  output logic [ADDR_W-1:0] lookupPa,
  output logic [DOM_W-1:0]  lookupDomain,
  output logic [AP_W-1:0]   lookupAp,
  output logic [CB_W-1:0]   lookupCb
);
  logic [ENTRIES-1:0] lookHit;
  logic [ENTRIES-1:0] invHit;
  logic [ENTRIES-1:0] firstHot;
  tlbEntry_t          picked [ENTRIES];
  tlbEntry_t          fillEntry;
  tlbEntry_t          sel;
  logic [FRAME_W-1:0] selMask;

  always_comb begin
    fillEntry.valid  = 1'b1;
    fillEntry.size   = pageSize_e'(fillSize);
    fillEntry.tag    = fillVa[ADDR_W-1:PAGE_LO];
    fillEntry.base   = fillPa[ADDR_W-1:PAGE_LO];
    fillEntry.domain = fillDomain;
    fillEntry.ap     = fillAp;
    fillEntry.cb     = fillCb;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    tlbEntry_t ent;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         ent       <= '0;
      else if (strobe.invAll)            ent.valid <= 1'b0;
      else if (strobe.invOne && invHit[i]) ent.valid <= 1'b0;
      else if (strobe.writeEn && strobe.writeIdx == STB_IDX_W'(i))
                                         ent       <= fillEntry;
    end
    assign lookHit[i] = entryMatch(ent, lookupVa);
    assign invHit[i]  = entryMatch(ent, invVa);
    assign picked[i]  = firstHot[i] ? ent : '0;
  end

  // lowest matching index wins
  assign firstHot = lookHit & (~lookHit + 1'b1);

  always_comb begin
    sel = '0;
    for (int i = 0; i < ENTRIES; i++) sel = sel | picked[i];
  end

  assign selMask = sizeMask(sel.size);

  always_comb begin
    if (xlateEn && (|lookHit)) begin
      lookupHit    = 1'b1;
      lookupPa     = {(sel.base & selMask) |
                      (lookupVa[ADDR_W-1:PAGE_LO] & ~selMask),
                      lookupVa[PAGE_LO-1:0]};
      lookupDomain = sel.domain;
      lookupAp     = sel.ap;
      lookupCb     = sel.cb;
    end else begin
      lookupHit    = 1'b0;
      lookupPa     = lookupVa;
      lookupDomain = '0;
      lookupAp     = '0;
      lookupCb     = '0;
    end
  end
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xlateEn,
  input  logic [31:0]       lookupVa,
  output logic              lookupHit,
  output logic [31:0]       lookupPa,
  output logic [3:0]        lookupDomain,
  output logic [1:0]        lookupAp,
  output logic [1:0]        lookupCb,
  input  logic              fillEn,
  input  logic [31:0]       fillVa,
  input  logic [31:0]       fillPa,
  input  logic [1:0]        fillSize,
  input  logic [3:0]        fillDomain,
  input  logic [1:0]        fillAp,
  input  logic [1:0]        fillCb,
  input  logic              invAll,
  input  logic              invEntry,
  input  logic [31:0]       invVa,
  input  logic [IDX_W:0]    lockBase
);
  tlbStrobe_t strobe;

  tlb_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .fillEn   (fillEn),
    .fillSize (fillSize),
    .invAll   (invAll),
    .invEntry (invEntry),
    .lockBase (lockBase),
    .strobe   (strobe)
  );

  tlb_array #(.ENTRIES(ENTRIES)) u_array (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .xlateEn      (xlateEn),
    .lookupVa     (lookupVa),
    .fillVa       (fillVa),
    .fillPa       (fillPa),
    .fillSize     (fillSize),
    .fillDomain   (fillDomain),
    .fillAp       (fillAp),
    .fillCb       (fillCb),
    .invVa        (invVa),
    .lookupHit    (lookupHit),
    .lookupPa     (lookupPa),
    .lookupDomain (lookupDomain),
    .lookupAp     (lookupAp),
    .lookupCb     (lookupCb)
  );
endmodule

// File: rtl/xlate_tlb_checker.sv
module xlate_tlb_checker
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input logic            clk,
  input logic            rstN,
  input logic            xlateEn,
  input logic [31:0]     lookupVa,
  input logic            lookupHit,
  input logic [31:0]     lookupPa,
  input logic            invAll,
  input logic            fillEn,
  input logic [1:0]      fillSize,
  input logic [IDX_W:0]  lockBase,
  input tlbStrobe_t      strobe
);
  // R1: pass-through while translation is off
  a_r1_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    !xlateEn |-> (lookupPa == lookupVa) && !lookupHit);

  // R4: page offset is never translated
  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    lookupHit |-> lookupPa[11:0] == lookupVa[11:0]);

  // R8: nothing hits right after a full clear
  a_r8_inv_all_empties: assert property (@(posedge clk) disable iff (!rstN)
    invAll |=> !lookupHit);

  // R7: writes stay in the unlocked, in-range part
  a_r7_no_locked_write: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeEn |-> (int'(strobe.writeIdx) >= int'(lockBase)) &&
                       (int'(strobe.writeIdx) < ENTRIES));

  // R10: at most one command acts per cycle
  a_r10_one_command: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.invAll, strobe.invOne, strobe.writeEn}));

  // R3: reserved size code never writes
  a_r3_rsvd_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn && fillSize == 2'b11) |-> !strobe.writeEn);

  // R6: back-to-back refills step the pointer and wrap to the lock base
  a_r6_pointer_step: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strobe.writeEn) && strobe.writeEn && $stable(lockBase)) |->
      (int'(strobe.writeIdx) ==
        ((int'($past(strobe.writeIdx)) == ENTRIES - 1) ? int'(lockBase)
                                                       : int'($past(strobe.writeIdx)) + 1)));
endmodule

bind xlate_tlb xlate_tlb_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .xlateEn  (xlateEn),
  .lookupVa (lookupVa),
  .lookupHit(lookupHit),
  .lookupPa (lookupPa),
  .invAll   (invAll),
  .fillEn   (fillEn),
  .fillSize (fillSize),
  .lockBase (lockBase),
  .strobe   (strobe)
);

// File: tb/xlate_tlb_bench.sv
module xlate_tlb_bench;
  localparam int ENT = 64;
  localparam int IW  = $clog2(ENT);

  logic        clk = 1'b0;
  logic        rstN;
  logic        xlateEn;
  logic [31:0] lookupVa;
  logic        lookupHit;
  logic [31:0] lookupPa;
  logic [3:0]  lookupDomain;
  logic [1:0]  lookupAp;
  logic [1:0]  lookupCb;
  logic        fillEn;
  logic [31:0] fillVa;
  logic [31:0] fillPa;
  logic [1:0]  fillSize;
  logic [3:0]  fillDomain;
  logic [1:0]  fillAp;
  logic [1:0]  fillCb;
  logic        invAll;
  logic        invEntry;
  logic [31:0] invVa;
  logic [IW:0] lockBase;

  always #5 clk = ~clk;

  xlate_tlb #(.ENTRIES(ENT)) u_xlate_tlb (.*);

  int checks = 0;
  int fails  = 0;

  // reference model
  bit          mValid [ENT];
  logic [1:0]  mSize  [ENT];
  logic [19:0] mTag   [ENT];
  logic [19:0] mBase  [ENT];
  logic [3:0]  mDom   [ENT];
  logic [1:0]  mAp    [ENT];
  logic [1:0]  mCb    [ENT];
  int          mPtr;

  function automatic logic [19:0] maskOf(logic [1:0] s);
    if (s == 2'b00)      return 20'hFFFFF;
    else if (s == 2'b01) return 20'hFFFF0;
    else                 return 20'hFFF00;
  endfunction

  function automatic bit mMatch(int i, logic [31:0] va);
    return mValid[i] && (((va[31:12] ^ mTag[i]) & maskOf(mSize[i])) == 20'h0);
  endfunction

  function automatic logic [40:0] expOut(logic [31:0] va);
    if (xlateEn) begin
      for (int i = 0; i < ENT; i++) begin
        if (mMatch(i, va)) begin
          logic [19:0] m;
          m = maskOf(mSize[i]);
          return {1'b1, (mBase[i] & m) | (va[31:12] & ~m), va[11:0],
                  mDom[i], mAp[i], mCb[i]};
        end
      end
    end
    return {1'b0, va, 4'h0, 2'b00, 2'b00};
  endfunction

  function automatic logic [31:0] randVa();
    return {12'(32'h400 + $urandom % 4), 4'($urandom % 4), 4'($urandom % 4),
            12'($urandom)};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expectLookup(string req, logic [31:0] va);
    lookupVa = va;
    #1;
    check(req, {23'h0, lookupHit, lookupPa, lookupDomain, lookupAp, lookupCb},
          {23'h0, expOut(va)});
  endtask

  task automatic modelCommit();
    int lock;
    lock = int'(lockBase);
    if (invAll) begin
      for (int i = 0; i < ENT; i++) mValid[i] = 1'b0;
    end else if (invEntry) begin
      for (int i = 0; i < ENT; i++) if (mMatch(i, invVa)) mValid[i] = 1'b0;
    end else if (fillEn && fillSize != 2'b11 && lock < ENT) begin
      int v;
      v = (mPtr < lock) ? lock : mPtr;
      mValid[v] = 1'b1; mSize[v] = fillSize; mTag[v] = fillVa[31:12];
      mBase[v] = fillPa[31:12]; mDom[v] = fillDomain; mAp[v] = fillAp; mCb[v] = fillCb;
      mPtr = (v == ENT - 1) ? lock : v + 1;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    modelCommit();
    @(negedge clk);
    fillEn = 1'b0; invAll = 1'b0; invEntry = 1'b0;
  endtask

  task automatic doFill(logic [31:0] va, logic [31:0] pa, logic [1:0] sz,
                        logic [3:0] dom, logic [1:0] ap, logic [1:0] cb);
    fillVa = va; fillPa = pa; fillSize = sz; fillDomain = dom; fillAp = ap; fillCb = cb;
    fillEn = 1'b1;
    tick();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    int hits;
    void'($urandom(32'h5EED_0001));
    rstN = 1'b0; xlateEn = 1'b0; lookupVa = '0; fillEn = 1'b0; fillVa = '0;
    fillPa = '0; fillSize = '0; fillDomain = '0; fillAp = '0; fillCb = '0;
    invAll = 1'b0; invEntry = 1'b0; invVa = '0; lockBase = '0;
    for (int i = 0; i < ENT; i++) mValid[i] = 1'b0;
    mPtr = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: pass-through while disabled
    expectLookup("R1", 32'h1234_5678);
    check("R1", {32'h0, lookupPa}, 64'h1234_5678);
    xlateEn = 1'b1;
    // R5: empty after reset -> miss
    expectLookup("R5", 32'h4000_0000);
    check("R5", {63'h0, lookupHit}, 64'h0);

    // R2/R4: section
    doFill(32'h4010_0000, 32'h8AB0_0000, 2'b10, 4'h9, 2'b11, 2'b10);
    expectLookup("R2", 32'h4017_6ABC);
    check("R4", {32'h0, lookupPa}, 64'h8AB7_6ABC);
    check("R2", {56'h0, lookupDomain, lookupAp, lookupCb}, 64'h9E);

    // R3: large page compare width
    doFill(32'h4020_0000, 32'h1234_0000, 2'b01, 4'h3, 2'b01, 2'b01);
    expectLookup("R3", 32'h4020_F123);
    check("R4", {32'h0, lookupPa}, 64'h1234_F123);
    expectLookup("R3", 32'h4021_0000);
    check("R3", {63'h0, lookupHit}, 64'h0);
    // R3: small page compare width
    doFill(32'h4030_5000, 32'h7777_7000, 2'b00, 4'h5, 2'b10, 2'b11);
    expectLookup("R3", 32'h4030_5FFF);
    check("R4", {32'h0, lookupPa}, 64'h7777_7FFF);
    expectLookup("R3", 32'h4030_6000);
    check("R3", {63'h0, lookupHit}, 64'h0);
    // R3: reserved size dropped
    doFill(32'h4040_0000, 32'hDEAD_0000, 2'b11, 4'h1, 2'b00, 2'b00);
    expectLookup("R3", 32'h4040_0123);
    check("R3", {63'h0, lookupHit}, 64'h0);

    // R11: small page (lower index) beats overlapping section
    doFill(32'h4030_0000, 32'h9990_0000, 2'b10, 4'h7, 2'b00, 2'b00);
    expectLookup("R11", 32'h4030_5123);
    check("R11", {32'h0, lookupPa}, 64'h7777_7123);
    expectLookup("R11", 32'h4030_8000);
    check("R11", {32'h0, lookupPa}, 64'h9990_8000);

    // R9: clear by address hits both overlapping entries only
    invVa = 32'h4030_5ABC; invEntry = 1'b1; tick();
    expectLookup("R9", 32'h4030_5123);
    check("R9", {63'h0, lookupHit}, 64'h0);
    expectLookup("R9", 32'h4010_0000);
    check("R9", {63'h0, lookupHit}, 64'h1);

    // R10: clear by address beats a refill in the same cycle
    fillVa = 32'h4050_0000; fillPa = 32'h1110_0000; fillSize = 2'b10; fillEn = 1'b1;
    invVa = 32'h4020_0000; invEntry = 1'b1; tick();
    expectLookup("R10", 32'h4050_0000);
    check("R10", {63'h0, lookupHit}, 64'h0);
    expectLookup("R10", 32'h4020_0000);
    // R10/R8: full clear beats a refill
    fillEn = 1'b1; invAll = 1'b1; tick();
    expectLookup("R8", 32'h4050_0000);
    check("R8", {63'h0, lookupHit}, 64'h0);
    expectLookup("R8", 32'h4010_0000);
    check("R8", {63'h0, lookupHit}, 64'h0);

    // R6: 65 refills overwrite the first one only
    for (int k = 0; k <= ENT; k++)
      doFill(32'h6000_0000 + (k << 12), 32'h0100_0000 + (k << 12), 2'b00,
             4'(k), 2'(k), 2'(k >> 2));
    expectLookup("R6", 32'h6000_0000);
    check("R6", {63'h0, lookupHit}, 64'h0);
    expectLookup("R6", 32'h6000_1000);
    check("R6", {63'h0, lookupHit}, 64'h1);
    expectLookup("R6", 32'h6004_0000);
    check("R6", {63'h0, lookupHit}, 64'h1);

    // R7: lock the first 8 entries, cycle the rest
    lockBase = 8;
    for (int k = 0; k < 70; k++)
      doFill(32'h7000_0000 + (k << 12), 32'h0200_0000 + (k << 12), 2'b00,
             4'h2, 2'b01, 2'b00);
    hits = 0;
    for (int k = 1; k <= ENT; k++) begin
      expectLookup("R7", 32'h6000_0000 + (k << 12));
      if (lookupHit) hits++;
    end
    check("R7", 64'(hits), 64'd8);
    // R7: all locked -> refill dropped
    lockBase = ENT;
    doFill(32'h7F00_0000, 32'h0300_0000, 2'b10, 4'h1, 2'b01, 2'b01);
    expectLookup("R7", 32'h7F00_0000);
    check("R7", {63'h0, lookupHit}, 64'h0);
    // R1: disabled again bypasses a valid entry
    xlateEn = 1'b0;
    expectLookup("R1", 32'h7000_1234);
    check("R1", {63'h0, lookupHit}, 64'h0);
    xlateEn = 1'b1;

    // random mix with reference model
    lockBase = 0;
    invAll = 1'b1; tick();
    for (int it = 0; it < 4000; it++) begin
      int op;
      op = int'($urandom % 100);
      if (op < 3) begin
        case ($urandom % 5)
          0: lockBase = 0;
          1: lockBase = 4;
          2: lockBase = 16;
          3: lockBase = (IW+1)'(ENT - 1);
          default: lockBase = (IW+1)'(ENT);
        endcase
      end
      xlateEn = ($urandom % 20) != 0;
      if (op < 50 || op >= 90) begin
        fillVa = randVa(); fillPa = $urandom;
        fillSize = (($urandom % 8) == 0) ? 2'b11 : 2'($urandom % 3);
        fillDomain = 4'($urandom); fillAp = 2'($urandom); fillCb = 2'($urandom);
        fillEn = 1'b1;
      end
      if ((op >= 50 && op < 56) || op >= 95) begin
        invEntry = 1'b1; invVa = randVa();
      end
      if (op == 57 || (op >= 90 && op < 92)) invAll = 1'b1;
      tick();
      expectLookup("R2", randVa());
      expectLookup("R9", invVa);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule